// File: doc/BRIEF.md
# Grade-Compensating Clock Enable Divider

This block sits directly after a PLL that runs near 294.912 MHz on every speed grade of the chip. It works on that fast clock and produces a system-clock enable plus a set of audio frame-rate pulses. A strap chooses the grade. The full-speed grade uses every PLL cycle as a system cycle. The reduced grade enables only every second PLL cycle, which gives an effective system clock of about 147.456 MHz.

Downstream of the system-clock enable, a base prescaler divides system cycles by 1024 on the full grade and by 512 on the reduced grade. The base rate is therefore 288 kHz on both grades. The logic that consumes the frame pulses cannot tell the grades apart.

A bank of frame generators then divides the base rate by a programmable integer ratio. Each generator gives a one-cycle enable per frame. A ratio of 6 gives 48 kHz. Nothing in the block is a derived clock: every output is an enable that is valid in the PLL clock domain.

Top module: `grade_clk_chain`

## Requirements
- R1: While reset is held, and until the internal release two PLL edges after `rst_n` rises, `sys_en` and every bit of `frame` are 0.
- R2: With the strap sampled low (full grade), `sys_en` is 1 on every PLL cycle after release.
- R3: With the strap sampled high (reduced grade), `sys_en` is 1 on the first running cycle and alternates every PLL cycle after that.
- R4: The base prescaler counts 1024 enabled cycles on the full grade and 512 on the reduced grade, so the base period is 1024 PLL cycles on either grade.
- R5: Generator g pulses once every 1024×N PLL cycles, where N is its effective ratio; a ratio of 6 gives one pulse per 6144 PLL cycles (48 kHz from 294.912 MHz).
- R6: Every frame pulse lasts exactly one PLL cycle and falls on a cycle where `sys_en` is 1.
- R7: A ratio field of 0 acts as 1, and a field above 16 acts as 16.
- R8: The grade strap is captured only while the internal reset is active; changing it later has no effect until the next reset.
- R9: Running cycles are numbered from 0 at release. The first pulse of generator g falls in cycle 1024N−1 on the full grade and 1024N−2 on the reduced grade.
- R10: Each generator takes its ratio from bits [5g+4:5g] of `ratio` and runs independently of the other generators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | PLL-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grade_half | input | 1 | Speed-grade strap, 1 = reduced grade (system = PLL/2) |
| ratio | input | NUM_GEN*5 | Per-generator frame ratio, 5 bits per generator |
| sys_en | output | 1 | System-clock enable |
| frame | output | NUM_GEN | One-cycle frame-rate pulses, one per generator |

## Verification
The assertions assume that `ratio` stays unchanged while a run is in progress. The stimulus changes it only while reset is held. The assertions also assume that the strap may move at any time, and the stimulus toggles it deep inside one run to show that it is ignored there. The bench sets the ratios to 0 and 20, so the property on the counter bound must hold even when the ratio field is out of range. Each generator's pulse times are predicted from the grade and the ratio alone and compared against what the design produces.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  parameter int unsigned GCC_RATIO_W = 5;
  parameter int unsigned GCC_RATIO_MAX = 16;

  typedef enum logic {
    GRADE_FULL = 1'b0,
    GRADE_HALF = 1'b1
  } grade_e;
endpackage

// File: rtl/gcc_en_gen.sv
module gcc_en_gen
  import gcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strap,
  output logic run,
  output logic half_sel,
  output logic sys_en
);
  logic   sync1_q, sync2_q;
  grade_e grade_q, grade_d;
  logic   phase_q, phase_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    grade_d = grade_q;
    if (!sync2_q) grade_d = strap ? GRADE_HALF : GRADE_FULL;
    phase_d = sync2_q ? ~phase_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grade_q <= GRADE_FULL;
      phase_q <= 1'b0;
    end else begin
      grade_q <= grade_d;
      phase_q <= phase_d;
    end
  end

  assign run      = sync2_q;
  assign half_sel = (grade_q == GRADE_HALF);
  assign sys_en   = sync2_q & ((grade_q == GRADE_FULL) | ~phase_q);

  a_r8_grade_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(half_sel));

  a_r3_half_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && half_sel) |-> (sys_en != $past(sys_en)));
endmodule

// File: rtl/gcc_base_div.sv
module gcc_base_div #(
  parameter int unsigned FULL_DIV = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic half_sel,
  input  logic sys_en,
  output logic base_tick
);
  localparam int unsigned CW = $clog2(FULL_DIV);
  localparam logic [CW-1:0] LIM_FULL = CW'(FULL_DIV - 1);
  localparam logic [CW-1:0] LIM_HALF = CW'(FULL_DIV / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          step;

  always_comb begin
    lim       = half_sel ? LIM_HALF : LIM_FULL;
    step      = run & sys_en;
    base_tick = step & (cnt_q >= lim);
    cnt_d     = cnt_q;
    if (step) cnt_d = base_tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r4_tick_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |-> sys_en);

  a_r4_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && half_sel) |-> (cnt_q <= LIM_HALF));
endmodule

// File: rtl/gcc_frame_gen.sv
module gcc_frame_gen
  import gcc_pkg::*;
#(
  parameter int unsigned RW   = GCC_RATIO_W,
  parameter int unsigned RMAX = GCC_RATIO_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_tick,
  input  logic [RW-1:0] ratio,
  output logic          pulse
);
  localparam logic [RW-1:0] RMAX_V = RW'(RMAX);

  logic [RW-1:0] ratio_eff, fcnt_q, fcnt_d;

  always_comb begin
    if (ratio == '0)         ratio_eff = RW'(1);
    else if (ratio > RMAX_V) ratio_eff = RMAX_V;
    else                     ratio_eff = ratio;
    pulse  = base_tick & (fcnt_q >= ratio_eff - 1'b1);
    fcnt_d = fcnt_q;
    if (base_tick) fcnt_d = pulse ? '0 : fcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fcnt_q <= '0;
    else        fcnt_q <= fcnt_d;
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_q < RMAX_V);

  a_r5_pulse_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> base_tick);
endmodule

// File: rtl/grade_clk_chain.sv
module grade_clk_chain
  import gcc_pkg::*;
#(
  parameter int unsigned NUM_GEN  = 2,
  parameter int unsigned FULL_DIV = 1024
) (
  input  logic                           clk_pll,
  input  logic                           rst_n,
  input  logic                           grade_half,
  input  logic [NUM_GEN*GCC_RATIO_W-1:0] ratio,
  output logic                           sys_en,
  output logic [NUM_GEN-1:0]             frame
);
  logic run, half_sel, base_tick;

  gcc_en_gen u_en (
    .clk      (clk_pll),
    .rst_n    (rst_n),
    .strap    (grade_half),
    .run      (run),
    .half_sel (half_sel),
    .sys_en   (sys_en)
  );

  gcc_base_div #(.FULL_DIV(FULL_DIV)) u_base (
    .clk       (clk_pll),
    .rst_n     (rst_n),
    .run       (run),
    .half_sel  (half_sel),
    .sys_en    (sys_en),
    .base_tick (base_tick)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    gcc_frame_gen u_fg (
      .clk       (clk_pll),
      .rst_n     (rst_n),
      .base_tick (base_tick),
      .ratio     (ratio[g*GCC_RATIO_W +: GCC_RATIO_W]),
      .pulse     (frame[g])
    );

    a_r6_single_cycle: assert property (@(posedge clk_pll) disable iff (!rst_n)
      frame[g] |=> !frame[g]);
  end

  a_r6_pulse_on_en: assert property (@(posedge clk_pll) disable iff (!rst_n)
    (|frame) |-> sys_en);

  a_r1_quiet_until_run: assert property (@(posedge clk_pll) disable iff (!rst_n)
    !run |-> (!sys_en && frame == '0));
endmodule

// File: tb/grade_clk_chain_tb.sv
`timescale 1ns/1ps
module grade_clk_chain_tb;
  localparam int CLK_P = 4;
  localparam int BASE  = 1024;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       grade_half;
  logic [9:0] ratio;
  logic       sys_en;
  logic [1:0] frame;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t0 = 0;
  bit running = 0;
  bit half_exp = 0;
  bit done = 0;
  int q0[$];
  int q1[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  grade_clk_chain u_dut (
    .clk_pll    (clk_pll_w),
    .rst_n      (rst_n),
    .grade_half (grade_half),
    .ratio      (ratio),
    .sys_en     (sys_en),
    .frame      (frame)
  );
  wire clk_pll_w = clk;

  function automatic int eff(input int r);
    if (r == 0) return 1;
    if (r > 16) return 16;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: compares sys_en pattern and pops predicted pulse times.
  always @(negedge clk) begin
    if (running) begin
      int k;
      int e;
      k = cyc - t0 - 2;
      if (k >= 0) begin
        e = half_exp ? ((k % 2 == 0) ? 1 : 0) : 1;
        chk(sys_en == e[0], half_exp ? "R3 sys_en alternation" : "R2 sys_en steady", sys_en, e);
        if (frame[0]) begin
          if (q0.size() == 0) chk(0, "R5 gen0 unexpected pulse", k, -1);
          else begin e = q0.pop_front(); chk(k == e, "R5/R9 gen0 pulse time", k, e); end
          chk(sys_en, "R6 pulse on sys_en", sys_en, 1);
        end
        if (frame[1]) begin
          if (q1.size() == 0) chk(0, "R10 gen1 unexpected pulse", k, -1);
          else begin e = q1.pop_front(); chk(k == e, "R10 gen1 pulse time", k, e); end
          chk(sys_en, "R6 pulse on sys_en", sys_en, 1);
        end
      end else begin
        chk(!sys_en && frame == 2'b00, "R1 quiet before release", {sys_en, frame}, 0);
      end
    end
  end

  // Driver: resets with a grade and ratios, pushes predicted pulses, runs.
  task automatic run_case(input bit half, input int r0, input int r1,
                          input int win, input int flip_at);
    int p0, p1, f0, f1;
    @(posedge clk); #1;
    rst_n = 1'b0;
    grade_half = half;
    ratio = {r1[4:0], r0[4:0]};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!sys_en && frame == 2'b00, "R1 reset outputs", {sys_en, frame}, 0);
    p0 = BASE * eff(r0);
    p1 = BASE * eff(r1);
    f0 = half ? p0 - 2 : p0 - 1;
    f1 = half ? p1 - 2 : p1 - 1;
    for (int k = f0; k <= win - 4; k += p0) q0.push_back(k);
    for (int k = f1; k <= win - 4; k += p1) q1.push_back(k);
    half_exp = half;
    @(posedge clk); #1;
    rst_n = 1'b1;
    t0 = cyc;
    running = 1'b1;
    for (int i = 0; i < win; i++) begin
      @(posedge clk); #1;
      if (i == flip_at) grade_half = ~grade_half; // R8 strap change ignored
    end
    running = 1'b0;
    chk(q0.size() == 0, "R5 gen0 missing pulses", q0.size(), 0);
    chk(q1.size() == 0, "R10 gen1 missing pulses", q1.size(), 0);
    q0.delete();
    q1.delete();
  endtask

  initial begin
    rst_n = 1'b0;
    grade_half = 1'b0;
    ratio = '0;
    run_case(1'b0, 6, 1, 20000, -1);    // R2 R4 R5 R9 full grade, 48 kHz
    run_case(1'b1, 6, 3, 20000, 3000);  // R3 R4 R8 R9 reduced grade, strap flips
    run_case(1'b0, 0, 16, 34000, -1);   // R7 ratio 0 and 16
    run_case(1'b1, 20, 2, 34000, 9000); // R7 ratio above range, R8 again
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule